// File: doc/BRIEF.md
# Thread Block and Warp Dispatcher

This block turns a kernel launch into a stream of warp descriptors. A launch names a block count and a thread count per block. The dispatcher takes the blocks in ascending order. It gives each one, whole, to a multiprocessor that reports spare room. It then cuts that block into 32-thread warps. Each warp is offered to one of the four warp schedulers of the chosen multiprocessor. A descriptor carries the block index, the index of its first thread and a 32-bit mask of the lanes that hold real threads.

Only one descriptor is on offer at a time, through a one-hot valid vector that names the target queue. A descriptor is taken when the ready bit of that queue is high at a clock edge. Each multiprocessor drives its own free bit, which stays high while it can take another block. Tracking how many blocks a multiprocessor holds is the multiprocessor's job. A launch with zero blocks or zero threads completes immediately. The done output stays high from the end of a launch until the next start is accepted.

Top module: `warp_dispatch`

## Requirements
- R1: While reset is held and on the first cycle after it, no valid bit is high and done is low.
- R2: A start with a block count of zero or a thread count of zero raises done one cycle later, and no valid bit is ever raised for that launch.
- R3: Blocks are dispatched in ascending index from 0. Each block goes to the lowest-numbered multiprocessor whose free bit is high when the block is placed. While no free bit is high, nothing is offered.
- R4: Every warp of a block targets the same multiprocessor.
- R5: A block of N threads produces ceil(N/32) warps. Their base thread indexes are 0, 32, 64 and so on, in ascending order.
- R6: The lane mask is all ones for a full warp. For a final warp with r threads (r < 32), bits 0 to r-1 are set and the rest are clear. Bit i stands for thread base+i.
- R7: Warp k of a block goes to scheduler k mod 4 of its multiprocessor. The valid bit raised is bit mp*4 + scheduler.
- R8: At most one valid bit is high at a time. While the target's ready bit is low, the valid bit and all descriptor fields hold unchanged.
- R9: Done rises on the cycle after the last warp is taken and stays high until a start is accepted. A start that arrives while a launch is still running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, taken only when no launch is running |
| num_blocks | input | BLK_W | Block count of the launch |
| num_threads | input | THR_W | Threads per block |
| mp_free | input | NUM_MP | Per-multiprocessor room for another block |
| sched_ready | input | NUM_MP*SCHEDS | Per-scheduler ready, bit mp*SCHEDS+s |
| warp_valid | output | NUM_MP*SCHEDS | One-hot descriptor valid, selects the target queue |
| warp_block | output | BLK_W | Block index of the descriptor |
| warp_base | output | THR_W | First thread index of the warp within its block |
| warp_mask | output | 32 | Lane-valid mask |
| done | output | 1 | Launch complete |

## Verification
The assertions check, on every cycle, the properties that hold locally. The valid vector is one-hot or zero. An offer held without ready keeps its fields frozen. No descriptor appears while done is high. Every mask has lane 0 set, and every base is 32-aligned. The assertions also check that done persists until a start arrives. Only the bench scenarios can show the ordering properties. These cover which multiprocessor each block lands on as free bits change, the count and order of warps per block, the partial-warp mask and the rotation across schedulers. The scenarios also show that a stray mid-launch start leaves the descriptor stream unchanged.

// File: rtl/warp_dispatch.sv
module warp_dispatch #(
  parameter int NUM_MP = 4,
  parameter int SCHEDS = 4,
  parameter int BLK_W  = 8,
  parameter int THR_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [BLK_W-1:0]         num_blocks,
  input  logic [THR_W-1:0]         num_threads,
  input  logic [NUM_MP-1:0]        mp_free,
  input  logic [NUM_MP*SCHEDS-1:0] sched_ready,
  output logic [NUM_MP*SCHEDS-1:0] warp_valid,
  output logic [BLK_W-1:0]         warp_block,
  output logic [THR_W-1:0]         warp_base,
  output logic [31:0]              warp_mask,
  output logic                     done
);
  localparam int LANES = 32;
  localparam int NQ    = NUM_MP * SCHEDS;
  localparam int MP_W  = (NUM_MP > 1) ? $clog2(NUM_MP) : 1;
  localparam int SCH_W = (SCHEDS > 1) ? $clog2(SCHEDS) : 1;
  localparam int Q_W   = (NQ > 1) ? $clog2(NQ) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SEL, S_EMIT} st_t;
  st_t st;

  logic [BLK_W-1:0] blk_cnt, blk_cur;
  logic [THR_W-1:0] thr_cnt, base;
  logic [MP_W-1:0]  mp_sel, mp_low;
  logic [SCH_W-1:0] sch;
  logic [Q_W-1:0]   tgt;
  logic [THR_W-1:0] remain;
  logic             accept, last_warp;

  always_comb begin
    mp_low = '0;
    for (int i = NUM_MP - 1; i >= 0; i--)
      if (mp_free[i]) mp_low = MP_W'(i);
  end

  assign tgt       = Q_W'(mp_sel) * Q_W'(SCHEDS) + Q_W'(sch);
  assign remain    = thr_cnt - base;
  assign last_warp = remain <= THR_W'(LANES);
  assign accept    = (st == S_EMIT) && sched_ready[tgt];

  assign warp_valid = (st == S_EMIT) ? (NQ'(1) << tgt) : '0;
  assign warp_block = blk_cur;
  assign warp_base  = base;
  assign warp_mask  = (remain >= THR_W'(LANES)) ? '1 : ((32'd1 << remain[4:0]) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      done    <= 1'b0;
      blk_cnt <= '0;
      blk_cur <= '0;
      thr_cnt <= '0;
      base    <= '0;
      mp_sel  <= '0;
      sch     <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          blk_cnt <= num_blocks;
          thr_cnt <= num_threads;
          blk_cur <= '0;
          if (num_blocks == '0 || num_threads == '0) done <= 1'b1;
          else begin
            done <= 1'b0;
            st   <= S_SEL;
          end
        end
        S_SEL: if (|mp_free) begin
          mp_sel <= mp_low;
          base   <= '0;
          sch    <= '0;
          st     <= S_EMIT;
        end
        S_EMIT: if (accept) begin
          base <= base + THR_W'(LANES);
          sch  <= (sch == SCH_W'(SCHEDS - 1)) ? '0 : sch + 1'b1;
          if (last_warp) begin
            blk_cur <= blk_cur + 1'b1;
            if (blk_cur == blk_cnt - 1'b1) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else st <= S_SEL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(warp_valid));

  // R8
  warp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(warp_valid & ~sched_ready)) |=>
      (warp_valid == $past(warp_valid)) && $stable(warp_base) &&
      $stable(warp_block) && $stable(warp_mask));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (warp_valid == '0));

  // R9
  done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R6
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|warp_valid) |-> (warp_mask[0] && (warp_base[4:0] == 5'd0)));
endmodule

// File: tb/sim_warp_dispatch.sv
module sim_warp_dispatch;
  localparam int NMP = 4;
  localparam int NS  = 4;
  localparam int NQ  = NMP * NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] num_blocks = '0;
  logic [9:0] num_threads = '0;
  logic [NMP-1:0] mp_free = '0;
  logic [NQ-1:0] sched_ready = '0;
  logic [NQ-1:0] warp_valid;
  logic [7:0] warp_block;
  logic [9:0] warp_base;
  logic [31:0] warp_mask;
  logic done;

  int vectors = 0;
  int errors  = 0;
  int cap [NMP];
  int cnt [NMP];
  int cyc = 0;

  always #10 clk = ~clk;

  warp_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .num_blocks(num_blocks),
    .num_threads(num_threads), .mp_free(mp_free), .sched_ready(sched_ready),
    .warp_valid(warp_valid), .warp_block(warp_block), .warp_base(warp_base),
    .warp_mask(warp_mask), .done(done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_free();
    for (int i = 0; i < NMP; i++) mp_free[i] = (cnt[i] < cap[i]);
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < NMP; i++) if (cnt[i] < cap[i]) return i;
    return -1;
  endfunction

  task automatic launch(input int m, input int n, input int c0, input int c1,
                        input int c2, input int c3, input bit stray);
    int eb, ew, nw, emp, idle, idx, rem;
    logic [31:0] em;
    bit r;
    cap[0] = c0; cap[1] = c1; cap[2] = c2; cap[3] = c3;
    for (int i = 0; i < NMP; i++) cnt[i] = 0;
    @(negedge clk);
    drive_free();
    num_blocks = 8'(m); num_threads = 10'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (m == 0 || n == 0) begin
      chk(done === 1'b1, "R2 done after empty launch", done, 1);
      for (int k = 0; k < 3; k++) begin
        chk(warp_valid == '0, "R2 no descriptor", warp_valid, 0);
        @(negedge clk);
      end
      return;
    end
    chk(done === 1'b0, "R9 done cleared by start", done, 0);
    eb = 0; ew = 0; nw = (n + 31) / 32; emp = 0; idle = 0;
    while (eb < m) begin
      if (warp_valid == '0) begin
        idle++;
        if (idle > 4) begin
          for (int i = 0; i < NMP; i++)
            if (cnt[i] > 0) begin cnt[i]--; break; end
          idle = 0;
        end
        sched_ready = NQ'($urandom);
      end else begin
        idle = 0;
        if (ew == 0) emp = lowest_free();
        idx = emp * NS + (ew % NS);
        rem = n - ew * 32;
        em = (rem >= 32) ? 32'hFFFF_FFFF : ((32'h1 << rem) - 32'h1);
        chk(warp_valid == (NQ'(1) << idx), "R3/R4/R7 target queue", warp_valid, NQ'(1) << idx);
        chk(warp_block == 8'(eb), "R3 block order", warp_block, eb);
        chk(warp_base == 10'(ew * 32), "R5 base index", warp_base, ew * 32);
        chk(warp_mask == em, "R6 lane mask", warp_mask, em);
        chk(done === 1'b0, "R9 done low while running", done, 0);
        r = ($urandom % 3) != 0;
        sched_ready = NQ'($urandom);
        sched_ready[idx] = r;
        if (r) begin
          if (ew == 0) cnt[emp]++;
          ew++;
          if (ew == nw) begin ew = 0; eb++; end
        end
      end
      if (stray && eb == 1 && ew == 0) begin
        start = 1'b1; num_blocks = 8'd0; num_threads = 10'd5;
      end else start = 1'b0;
      drive_free();
      @(negedge clk);
    end
    start = 1'b0;
    chk(done === 1'b1, "R9 done after last warp", done, 1);
    chk(warp_valid == '0, "R9 quiet when done", warp_valid, 0);
    @(negedge clk);
    chk(done === 1'b1, "R9 done held", done, 1);
  endtask

  initial begin
    int ns [12] = '{1, 31, 32, 33, 63, 64, 65, 100, 127, 128, 129, 200};
    int ms [3]  = '{1, 3, 6};
    for (int i = 0; i < NMP; i++) begin cap[i] = 0; cnt[i] = 0; end
    repeat (3) begin
      @(negedge clk);
      chk(warp_valid == '0, "R1 reset valid", warp_valid, 0);
      chk(done === 1'b0, "R1 reset done", done, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(warp_valid == '0 && done === 1'b0, "R1 after reset", {warp_valid, done}, 0);
    launch(0, 40, 1, 1, 1, 1, 0);
    launch(3, 0, 1, 1, 1, 1, 0);
    launch(0, 0, 1, 1, 1, 1, 0);
    for (int a = 0; a < 12; a++)
      for (int b = 0; b < 3; b++) begin
        launch(ms[b], ns[a], 2, 1, 3, 1, 0);
        launch(ms[b], ns[a], 0, 2, 0, 1, (a % 2) == 0);
        launch(ms[b], ns[a], 1, 1, 1, 1, 1);
      end
    launch(9, 1, 1, 0, 0, 0, 0);
    launch(5, 1000, 1, 1, 1, 1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule